// File: doc/BRIEF.md
# DDR Burst-of-Four Synchronous SRAM

This block is a synthesizable pipelined synchronous SRAM that has a double-data-rate data interface and a fixed burst length of four words. It runs from a single clock `clk` at twice the rate of the notional primary clock. Each rising edge of `clk` is one phase of the primary clock. Even edges, counted from reset release, stand for the primary rising edge. Odd edges stand for the rising edge of its complement.

The block repeats a four-edge slot pattern:

- edge 0: read-address slot
- edge 1: complement phase
- edge 2: write-address slot
- edge 3: complement phase

One shared address bus therefore carries read and write addresses on alternating primary edges. A write moves four data words, one per phase. A read returns four words, one per phase, with a latency of 1.5 primary cycles. A pair of complementary echo clocks runs alongside the read data so that a receiver can capture it.

Every address names a group of four words. The parameter `BURST_FROM_ADDR` selects how the burst starts:

- Narrow configuration (`BURST_FROM_ADDR=0`): the whole address selects the group and the burst always starts at word 0.
- Wide configuration (`BURST_FROM_ADDR=1`): the upper address bits select the group, and the two lowest bits give the starting word.

In both configurations the burst steps through the group in increasing order and wraps modulo four.

Top module: `ddr_b4_sram`

## Requirements
- R1: While `rst_n` is low and after reset, `rvalid` is 0, `rdata` is 0, `echo_p` is 0 and `echo_n` is 1. The first rising `clk` edge after release is a read-address slot, and slots repeat every four edges as read-address, complement, write-address, complement.
- R2: With `BURST_FROM_ADDR=0`, the address selects a group of four words, and every burst starts at word 0 of that group (word index = address*4 + beat).
- R3: With `BURST_FROM_ADDR=1`, `addr[ADDR_W-1:2]` selects the group and `addr[1:0]` gives the first word of the burst.
- R4: The four words of a burst follow start, start+1, start+2, start+3 modulo four. For example, start 3 gives words 3, 0, 1, 2.
- R5: `wr_sel_n` low at a write-address slot edge captures `addr`. The `wdata` sampled at that edge and at the next three edges is written as beats 0 to 3.
- R6: `rd_sel_n` low at a read-address slot edge E captures `addr`. The four words are presented after edges E+3 through E+6, with `rvalid` high for exactly those cycles.
- R7: When no read beat is presented, `rvalid` is 0 and `rdata` is 0. A write slot with `wr_sel_n` high modifies no word.
- R8: `rd_sel_n` low outside a read-address slot, and `wr_sel_n` low outside a write-address slot, start no access and produce no output.
- R9: Reads selected in consecutive read-address slots produce an unbroken stream of valid beats.
- R10: A read in the read-address slot that directly follows a write to the same address returns the newly written words.
- R11: `echo_n` is always the complement of `echo_p`, and both toggle on every `clk` edge. `echo_p` is 1 after the slot edges 0 and 2. The first beat of each read burst appears together with a rising edge of `echo_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; each rising edge is one phase of the primary clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Shared read/write address, sampled on address slots |
| rd_sel_n | input | 1 | Active-low read select, sampled on read-address slots |
| wr_sel_n | input | 1 | Active-low write select, sampled on write-address slots |
| wdata | input | DATA_W | Write data, one word per phase |
| rdata | output | DATA_W | Registered read data, one word per phase, 0 when idle |
| rvalid | output | 1 | High while `rdata` carries a burst beat |
| echo_p | output | 1 | Echo clock, edge-aligned with read data |
| echo_n | output | 1 | Complement echo clock |

## Verification
The embedded properties check, on every cycle, the following:

- the echo pair toggles and stays complementary;
- `rdata` is zero whenever no beat is valid;
- every valid run is a whole multiple of four beats;
- each burst begins on an `echo_n` rising edge;
- the write beat index steps by one modulo four;
- reads and writes never overlap their own previous burst.

Only the bench's scenarios can show the rest, because it depends on the stored contents. This covers whether the right word lands in the right location for both start modes, whether a read directly after a write sees the new data, and whether deselected or off-slot selects leave the array untouched. The bench shows this by comparing every presented beat against a reference model of the array.

// File: rtl/ddrb4_pkg.sv
package ddrb4_pkg;

    // Position within the four-phase slot pattern (two primary clock cycles).
    typedef enum logic [1:0] {
        SLOT_RD_ADDR = 2'd0,
        SLOT_RD_HALF = 2'd1,
        SLOT_WR_ADDR = 2'd2,
        SLOT_WR_HALF = 2'd3
    } slot_e;

    function automatic slot_e slot_next(input slot_e s);
        logic [1:0] v;
        v = s;
        v = v + 2'd1;
        return slot_e'(v);
    endfunction

    // Word within a group for a given burst start and beat, wrapping modulo four.
    function automatic logic [1:0] beat_pos(input logic [1:0] st, input logic [1:0] k);
        return st + k;
    endfunction

endpackage

// File: rtl/ddrb4_in_reg.sv
module ddrb4_in_reg
    import ddrb4_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 18,
    parameter int FROM_ADDR = 1,
    parameter int GRP_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [DATA_W-1:0] wdata_i,
    output slot_e             phase_o,
    output slot_e             tag_o,
    output logic [GRP_W-1:0]  grp_o,
    output logic [1:0]        start_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic [DATA_W-1:0] wdata_o
);

    typedef struct packed {
        slot_e             phase;
        slot_e             tag;
        logic [ADDR_W-1:0] addr;
        logic              rd_n;
        logic              wr_n;
        logic [DATA_W-1:0] wd;
    } in_st_t;

    in_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = slot_next(st_q.phase);
        st_d.tag   = st_q.phase;
        st_d.addr  = addr_i;
        st_d.rd_n  = rd_n_i;
        st_d.wr_n  = wr_n_i;
        st_d.wd    = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= SLOT_RD_ADDR;
            st_q.tag   <= SLOT_WR_HALF;
            st_q.addr  <= '0;
            st_q.rd_n  <= 1'b1;
            st_q.wr_n  <= 1'b1;
            st_q.wd    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (FROM_ADDR != 0) begin : g_start_from_addr
            assign grp_o   = st_q.addr[ADDR_W-1:2];
            assign start_o = st_q.addr[1:0];
        end else begin : g_start_zero
            assign grp_o   = st_q.addr;
            assign start_o = 2'b00;
        end
    endgenerate

    assign phase_o = st_q.phase;
    assign tag_o   = st_q.tag;
    assign rd_n_o  = st_q.rd_n;
    assign wr_n_o  = st_q.wr_n;
    assign wdata_o = st_q.wd;

    // R1
    property p_phase_step;
        @(posedge clk) disable iff (!rst_n)
            st_q.tag == SLOT_RD_ADDR |-> st_q.phase == SLOT_RD_HALF;
    endproperty
    phase_step_chk: assert property (p_phase_step);

endmodule

// File: rtl/ddrb4_wr_ctrl.sv
module ddrb4_wr_ctrl
    import ddrb4_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int GRP_W  = 4,
    parameter int IDX_W  = GRP_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             tag_i,
    input  logic [GRP_W-1:0]  grp_i,
    input  logic [1:0]        start_i,
    input  logic              wr_n_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              we_o,
    output logic [IDX_W-1:0]  widx_o,
    output logic [DATA_W-1:0] wd_o
);

    typedef struct packed {
        logic             act;
        logic [GRP_W-1:0] grp;
        logic [1:0]       start;
        logic [1:0]       cnt;
    } wr_st_t;

    wr_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        we_o   = 1'b0;
        widx_o = '0;
        if (tag_i == SLOT_WR_ADDR && !wr_n_i) begin
            we_o       = 1'b1;
            widx_o     = {grp_i, start_i};
            st_d.act   = 1'b1;
            st_d.grp   = grp_i;
            st_d.start = start_i;
            st_d.cnt   = 2'd1;
        end else if (st_q.act) begin
            we_o     = 1'b1;
            widx_o   = {st_q.grp, beat_pos(st_q.start, st_q.cnt)};
            st_d.cnt = st_q.cnt + 2'd1;
            if (st_q.cnt == 2'd3) begin
                st_d.act = 1'b0;
            end
        end
    end

    assign wd_o = wdata_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    property p_wr_seq;
        @(posedge clk) disable iff (!rst_n)
            (st_q.act && $past(we_o)) |-> widx_o[1:0] == 2'($past(widx_o[1:0]) + 2'd1);
    endproperty
    wr_seq_chk: assert property (p_wr_seq);

    // R5
    property p_wr_no_overlap;
        @(posedge clk) disable iff (!rst_n)
            tag_i == SLOT_WR_ADDR |-> !st_q.act;
    endproperty
    wr_no_overlap_chk: assert property (p_wr_no_overlap);

endmodule

// File: rtl/ddrb4_rd_ctrl.sv
module ddrb4_rd_ctrl
    import ddrb4_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int GRP_W  = 4,
    parameter int IDX_W  = GRP_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             phase_i,
    input  slot_e             tag_i,
    input  logic [GRP_W-1:0]  grp_i,
    input  logic [1:0]        start_i,
    input  logic              rd_n_i,
    input  logic [DATA_W-1:0] mem_i,
    output logic [IDX_W-1:0]  ridx_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              echo_p_o,
    output logic              echo_n_o
);

    typedef struct packed {
        logic              pend;
        logic [GRP_W-1:0]  pgrp;
        logic [1:0]        pstart;
        logic              act;
        logic [GRP_W-1:0]  grp;
        logic [1:0]        start;
        logic [1:0]        beat;
        logic [DATA_W-1:0] dout;
        logic              vld;
        logic              ep;
        logic              en;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        ridx_o = {st_q.grp, beat_pos(st_q.start, st_q.beat)};

        // address stage: one slot of wait before the burst engine starts
        st_d.pend = (tag_i == SLOT_RD_ADDR) && !rd_n_i;
        if (st_d.pend) begin
            st_d.pgrp   = grp_i;
            st_d.pstart = start_i;
        end

        // burst engine
        if (st_q.pend) begin
            st_d.act   = 1'b1;
            st_d.grp   = st_q.pgrp;
            st_d.start = st_q.pstart;
            st_d.beat  = 2'd0;
        end else if (st_q.act) begin
            st_d.beat = st_q.beat + 2'd1;
            if (st_q.beat == 2'd3) begin
                st_d.act = 1'b0;
            end
        end

        // output register stage
        st_d.vld  = st_q.act;
        st_d.dout = st_q.act ? mem_i : '0;

        // echo clocks follow the phase of the edge that loads the output
        st_d.ep = (phase_i == SLOT_RD_ADDR) || (phase_i == SLOT_WR_ADDR);
        st_d.en = (phase_i == SLOT_RD_HALF) || (phase_i == SLOT_WR_HALF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o  = st_q.dout;
    assign rvalid_o = st_q.vld;
    assign echo_p_o = st_q.ep;
    assign echo_n_o = st_q.en;

    // checker state
    logic [1:0] run_q;
    logic       arm_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 2'd0;
            arm_q <= 1'b0;
        end else begin
            run_q <= rvalid_o ? run_q + 2'd1 : 2'd0;
            arm_q <= 1'b1;
        end
    end

    // R6
    property p_burst_len;
        @(posedge clk) disable iff (!rst_n)
            $fell(rvalid_o) |-> run_q == 2'd0;
    endproperty
    burst_len_chk: assert property (p_burst_len);

    // R7
    property p_idle_zero;
        @(posedge clk) disable iff (!rst_n)
            !rvalid_o |-> rdata_o == '0;
    endproperty
    idle_zero_chk: assert property (p_idle_zero);

    // R11
    property p_echo_toggle;
        @(posedge clk) disable iff (!rst_n)
            arm_q |-> (echo_p_o != $past(echo_p_o)) && (echo_n_o != echo_p_o);
    endproperty
    echo_toggle_chk: assert property (p_echo_toggle);

    // R11
    property p_first_beat_echo;
        @(posedge clk) disable iff (!rst_n)
            $rose(rvalid_o) |-> $rose(echo_n_o);
    endproperty
    first_beat_echo_chk: assert property (p_first_beat_echo);

    // R9
    property p_rd_no_overlap;
        @(posedge clk) disable iff (!rst_n)
            st_q.pend |-> (!st_q.act || st_q.beat == 2'd3);
    endproperty
    rd_no_overlap_chk: assert property (p_rd_no_overlap);

endmodule

// File: rtl/ddrb4_array.sv
module ddrb4_array #(
    parameter int DATA_W = 18,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wd_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rd_o
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[widx_i] <= wd_i;
        end
    end

    assign rd_o = mem_q[ridx_i];

endmodule

// File: rtl/ddr_b4_sram.sv
module ddr_b4_sram
    import ddrb4_pkg::*;
#(
    parameter int ADDR_W          = 6,
    parameter int DATA_W          = 18,
    parameter int BURST_FROM_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              echo_p,
    output logic              echo_n
);

    localparam int GRP_W = (BURST_FROM_ADDR != 0) ? ADDR_W - 2 : ADDR_W;
    localparam int IDX_W = GRP_W + 2;

    slot_e             phase, tag;
    logic [GRP_W-1:0]  grp;
    logic [1:0]        start;
    logic              rd_n_r, wr_n_r;
    logic [DATA_W-1:0] wd_r;
    logic              we;
    logic [IDX_W-1:0]  widx, ridx;
    logic [DATA_W-1:0] wd_arr, rd_arr;

    ddrb4_in_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FROM_ADDR(BURST_FROM_ADDR), .GRP_W(GRP_W)
    ) u_in (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_n_i(rd_sel_n), .wr_n_i(wr_sel_n),
        .wdata_i(wdata), .phase_o(phase), .tag_o(tag), .grp_o(grp), .start_o(start),
        .rd_n_o(rd_n_r), .wr_n_o(wr_n_r), .wdata_o(wd_r)
    );

    ddrb4_wr_ctrl #(.DATA_W(DATA_W), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .tag_i(tag), .grp_i(grp), .start_i(start),
        .wr_n_i(wr_n_r), .wdata_i(wd_r), .we_o(we), .widx_o(widx), .wd_o(wd_arr)
    );

    ddrb4_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_arr (
        .clk(clk), .we_i(we), .widx_i(widx), .wd_i(wd_arr), .ridx_i(ridx), .rd_o(rd_arr)
    );

    ddrb4_rd_ctrl #(.DATA_W(DATA_W), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .tag_i(tag), .grp_i(grp),
        .start_i(start), .rd_n_i(rd_n_r), .mem_i(rd_arr), .ridx_o(ridx),
        .rdata_o(rdata), .rvalid_o(rvalid), .echo_p_o(echo_p), .echo_n_o(echo_n)
    );

endmodule

// File: tb/ddr_b4_sram_tb.sv
module ddr_b4_sram_tb;

    localparam int AW = 6;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata_w, rdata_n;
    logic          rvalid_w, rvalid_n, ep_w, en_w, ep_n, en_n;

    always #10 clk = ~clk;

    ddr_b4_sram #(.ADDR_W(AW), .DATA_W(DW), .BURST_FROM_ADDR(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .wdata(wdata), .rdata(rdata_w), .rvalid(rvalid_w), .echo_p(ep_w), .echo_n(en_w)
    );

    ddr_b4_sram #(.ADDR_W(AW), .DATA_W(DW), .BURST_FROM_ADDR(0)) u_dut_nar (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .wdata(wdata), .rdata(rdata_n), .rvalid(rvalid_n), .echo_p(ep_n), .echo_n(en_n)
    );

    // reference model of both arrays
    logic [DW-1:0] mw [64];
    bit            kw [64];
    logic [DW-1:0] mn [256];
    bit            kn [256];
    bit            exp_v [8];
    int            exp_iw [8];
    int            exp_in [8];
    bit            pc_v = 0;
    int            pc_iw, pc_in;
    logic [DW-1:0] pc_d;
    bit            wact = 0;
    int            wk = 0;
    logic [AW-1:0] waddr;
    int            wr_left = 0;
    logic [DW-1:0] wnext;
    int            n = 0;
    int            checks = 0;
    int            fails = 0;
    bit            done = 0;
    string         cur_req = "R6";

    // {req[3:0], rd_en, rd_addr[5:0], wr_en, wr_addr[5:0], seed[17:0]}
    localparam int NV = 11;
    localparam logic [35:0] VEC [NV] = '{
        {4'd5,  1'b0, 6'h00, 1'b1, 6'h05, 18'h00100},  // R5 first write
        {4'd10, 1'b1, 6'h05, 1'b1, 6'h0A, 18'h00200},  // R10 read right after write
        {4'd10, 1'b1, 6'h0A, 1'b1, 6'h13, 18'h00300},  // R10
        {4'd4,  1'b1, 6'h13, 1'b1, 6'h20, 18'h00400},  // R4 start 3 wraps
        {4'd9,  1'b1, 6'h20, 1'b0, 6'h00, 18'h00000},  // R9 back-to-back reads
        {4'd3,  1'b1, 6'h06, 1'b0, 6'h3F, 18'h00000},  // R3 start from low bits
        {4'd7,  1'b0, 6'h00, 1'b0, 6'h13, 18'h00000},  // R7 idle, deselected write
        {4'd6,  1'b1, 6'h13, 1'b1, 6'h05, 18'h00500},  // R6 readback after deselect
        {4'd10, 1'b1, 6'h05, 1'b1, 6'h2F, 18'h00600},  // R10 overwrite
        {4'd3,  1'b1, 6'h2C, 1'b0, 6'h00, 18'h00000},  // R3 start 0 of wrapped group
        {4'd7,  1'b0, 6'h00, 1'b0, 6'h00, 18'h00000}   // R7 drain
    };

    function automatic int idx_w(input logic [AW-1:0] a, input int k);
        return (int'(a) / 4) * 4 + ((int'(a) + k) % 4);
    endfunction

    function automatic int idx_n(input logic [AW-1:0] a, input int k);
        return int'(a) * 4 + k;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (edge %0d)", req, act, exp, n);
        end
    endtask

    // Called just after a falling edge: drives inputs, models one rising edge, checks.
    task automatic step(input bit rs_n, input bit ws_n, input logic [AW-1:0] a,
                        input logic [DW-1:0] seed);
        int s;
        bit e;
        int iw, in_;
        s = n % 4;
        rd_sel_n = rs_n;
        wr_sel_n = ws_n;
        addr = a;
        if (s == 2 && !ws_n) begin
            wdata = seed; wr_left = 3; wnext = seed + 1'b1;
        end else if (wr_left > 0) begin
            wdata = wnext; wnext = wnext + 1'b1; wr_left--;
        end else begin
            wdata = 18'h2A5A5;
        end
        @(posedge clk);
        e = exp_v[n % 8]; iw = exp_iw[n % 8]; in_ = exp_in[n % 8];
        exp_v[n % 8] = 0;
        if (pc_v) begin
            mw[pc_iw] = pc_d; kw[pc_iw] = 1;
            mn[pc_in] = pc_d; kn[pc_in] = 1;
            pc_v = 0;
        end
        if (s == 0 && !rs_n) begin
            for (int k = 0; k < 4; k++) begin
                exp_v[(n + 3 + k) % 8]  = 1;
                exp_iw[(n + 3 + k) % 8] = idx_w(a, k);
                exp_in[(n + 3 + k) % 8] = idx_n(a, k);
            end
        end
        if (s == 2 && !ws_n) begin
            wact = 1; wk = 0; waddr = a;
        end
        if (wact) begin
            pc_v = 1; pc_iw = idx_w(waddr, wk); pc_in = idx_n(waddr, wk); pc_d = wdata;
            wk++;
            if (wk == 4) wact = 0;
        end
        #2;
        // R11 echo pair follows the slot of this edge
        chk("R11", {30'd0, ep_w, en_w}, (s % 2 == 0) ? 32'd2 : 32'd1);
        chk("R11", {30'd0, ep_n, en_n}, (s % 2 == 0) ? 32'd2 : 32'd1);
        if (e) begin
            chk(cur_req, {31'd0, rvalid_w}, 32'd1);
            if (kw[iw]) chk(cur_req, {14'd0, rdata_w}, {14'd0, mw[iw]});
            chk("R2", {31'd0, rvalid_n}, 32'd1);
            if (kn[in_]) chk("R2", {14'd0, rdata_n}, {14'd0, mn[in_]});
        end else begin
            chk("R7", {13'd0, rvalid_w, rdata_w}, 32'd0);
            chk("R7", {13'd0, rvalid_n, rdata_n}, 32'd0);
        end
        n++;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [35:0] v;
        for (int i = 0; i < 8; i++) exp_v[i] = 0;
        for (int i = 0; i < 64; i++) kw[i] = 0;
        for (int i = 0; i < 256; i++) kn[i] = 0;

        // R1 reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R1", {12'd0, rvalid_w, rdata_w, ep_w, en_w}, 32'd1);
        chk("R1", {12'd0, rvalid_n, rdata_n, ep_n, en_n}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // vector table walk: one read slot and one write slot per entry
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            cur_req = $sformatf("R%0d", int'(v[35:32]));
            step(!v[31], 1'b1, v[30:25], '0);
            step(1'b1, 1'b1, 6'h3F, '0);
            step(1'b1, !v[24], v[23:18], v[17:0]);
            step(1'b1, 1'b1, 6'h3F, '0);
        end

        // R8: selects on the wrong slots must start nothing
        cur_req = "R8";
        step(1'b1, 1'b0, 6'h05, 18'h07777);
        step(1'b0, 1'b0, 6'h05, 18'h07777);
        step(1'b0, 1'b1, 6'h05, 18'h07777);
        step(1'b0, 1'b0, 6'h05, 18'h07777);
        // readback of 05 and 13 shows the array untouched (R8, R7)
        step(1'b0, 1'b1, 6'h05, '0);
        step(1'b1, 1'b1, 6'h00, '0);
        step(1'b1, 1'b1, 6'h00, '0);
        step(1'b1, 1'b1, 6'h00, '0);
        cur_req = "R7";
        step(1'b0, 1'b1, 6'h13, '0);
        repeat (11) step(1'b1, 1'b1, 6'h00, '0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule